// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Global Enable

This block collects interrupt events from one external source and from a set of timer sources on behalf of a small processor core. Each event is held in its own request flag. A request becomes an interrupt request to the core only when its source enable is set and the global enable is set. When more than one request qualifies, a fixed priority picks the winner. The block presents the winner to the core as a vector index.

The core reports each instruction boundary with a one-cycle strobe. An interrupt is taken only on such a strobe. In the cycle it is taken, the block clears the request flag of the chosen source and clears the global enable, so the handler starts with further interrupts masked. A return-from-interrupt strobe from the core sets the global enable again. A handler that wants nesting sets the global enable itself through a register write. Software sees the controls as two 8-bit registers. Any subset of bits can be written in one access through a bit mask, so single-bit set and clear operations do not disturb the other bits.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, both registers read zero and `irq_o` and `take_o` are low.
- R2: An event on `src_evt_i[k]` sets request flag k at the next clock edge, whatever the source enable and the global enable are.
- R3: `irq_o` is high exactly when the global enable is set and at least one source has both its flag and its enable set.
- R4: Source index 0 is the external source, and indices 1 and 2 are timer 0 and timer 1. When `irq_o` is high, `vec_o` is the lowest index whose flag and enable are both set, so the external source beats timer 0, which beats timer 1.
- R5: `take_o` is high in a cycle exactly when `boundary_i` and `irq_o` are both high. No interrupt is taken without a boundary strobe.
- R6: At the clock edge that ends a take cycle, the global enable clears and the flag of the source named by `vec_o` clears. The other flags keep their values.
- R7: `reti_i` sets the global enable at the next edge when no take happens in the same cycle.
- R8: Writes are selected by `wr_sel_i`. A value of 0 selects the control register, where bit 0 is the global enable and bit k+1 is the enable of source k. A value of 1 selects the flag register, where bit k is the flag of source k. Only the bits set in `wr_mask_i` take the value of `wr_data_i`. All other bits keep their value. Bits with no function read zero.
- R9: An event on a source in the same cycle as that source is taken leaves its flag set.
- R10: A take in the same cycle as a software write of 1 to the global enable, or as `reti_i`, leaves the global enable clear.
- R11: Inside a handler, a software write that sets the global enable allows the next pending request to be taken at the next boundary strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_evt_i | input | NUM_SRC | One-cycle event per source (0 external, then timers) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Register select for writes (0 control, 1 flags) |
| wr_mask_i | input | 8 | Bits to update on a write |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Register select for reads (0 control, 1 flags) |
| rd_data_o | output | 8 | Selected register contents |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| reti_i | input | 1 | Return-from-interrupt strobe from the core |
| irq_o | output | 1 | A qualified request is pending |
| take_o | output | 1 | The interrupt is taken in this cycle |
| vec_o | output | VEC_W | Index of the winning source |

## Verification
The risky collisions are cycles where a take meets another update of the same state bit. One case is a new event on the source being taken, where the flag must stay set. The other is a take meeting either a software write that sets the global enable or a return strobe, where the global enable must end clear. The bench drives each collision in a single cycle by raising the boundary strobe together with the event, the write or the return strobe. A behavioural model applies the stated precedence, and both registers and the core-facing outputs are compared against that model every clock.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned MASTER_POS = 0;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_FLAG = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N = 3,
  parameter int unsigned W = 2
) (
  input  logic [N-1:0] req_i,
  output logic         valid_o,
  output logic [W-1:0] idx_o,
  output logic [N-1:0] grant_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = i[W-1:0];
    end
  end

  // lowest set bit wins
  assign grant_o = req_i & (~req_i + {{(N-1){1'b0}}, 1'b1});
  assign valid_o = |req_i;
endmodule

// File: rtl/irq_master_bit.sv
module irq_master_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_wr_i,
  input  logic sw_val_i,
  input  logic reti_i,
  input  logic take_i,
  output logic master_o
);
  logic master_d;

  // precedence: take > reti > software
  always_comb begin
    master_d = master_o;
    if (sw_wr_i) master_d = sw_val_i;
    if (reti_i)  master_d = 1'b1;
    if (take_i)  master_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) master_o <= 1'b0;
    else         master_o <= master_d;
  end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned REG_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               ctrl_wr_i,
  input  logic               flag_wr_i,
  input  logic [REG_W-1:0]   mask_i,
  input  logic [REG_W-1:0]   data_i,
  input  logic               take_i,
  input  logic [NUM_SRC-1:0] grant_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] flag_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic en_d;
    logic flag_d;

    always_comb begin
      en_d = en_o[g];
      if (ctrl_wr_i && mask_i[g+1]) en_d = data_i[g+1];
    end

    // precedence: event > take clear > software
    always_comb begin
      flag_d = flag_o[g];
      if (flag_wr_i && mask_i[g]) flag_d = data_i[g];
      if (take_i && grant_i[g])   flag_d = 1'b0;
      if (evt_i[g])               flag_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[g]   <= 1'b0;
        flag_o[g] <= 1'b0;
      end else begin
        en_o[g]   <= en_d;
        flag_o[g] <= flag_d;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter  int unsigned NUM_SRC = 3,
  localparam int unsigned VEC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_evt_i,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [REG_W-1:0]   wr_mask_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic               rd_sel_i,
  output logic [REG_W-1:0]   rd_data_o,
  input  logic               boundary_i,
  input  logic               reti_i,
  output logic               irq_o,
  output logic               take_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic               ctrl_wr;
  logic               flag_wr;
  logic               master_q;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] grant;
  logic [REG_W-1:0]   ctrl_word;
  logic [REG_W-1:0]   flag_word;
  logic               unused_hi;

  assign unused_hi = ^{wr_mask_i[REG_W-1:NUM_SRC+1], wr_data_i[REG_W-1:NUM_SRC+1]};

  assign ctrl_wr = wr_en_i && (wr_sel_i == REG_CTRL);
  assign flag_wr = wr_en_i && (wr_sel_i == REG_FLAG);

  assign pending = flag_q & en_q & {NUM_SRC{master_q}};
  assign take_o  = boundary_i && irq_o;

  irq_prio_enc #(.N(NUM_SRC), .W(VEC_W)) u_prio (
    .req_i   (pending),
    .valid_o (irq_o),
    .idx_o   (vec_o),
    .grant_o (grant)
  );

  irq_master_bit u_master (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_wr_i  (ctrl_wr && wr_mask_i[MASTER_POS]),
    .sw_val_i (wr_data_i[MASTER_POS]),
    .reti_i   (reti_i),
    .take_i   (take_o),
    .master_o (master_q)
  );

  irq_src_bank #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (src_evt_i),
    .ctrl_wr_i (ctrl_wr),
    .flag_wr_i (flag_wr),
    .mask_i    (wr_mask_i),
    .data_i    (wr_data_i),
    .take_i    (take_o),
    .grant_i   (grant),
    .en_o      (en_q),
    .flag_o    (flag_q)
  );

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[MASTER_POS]    = master_q;
    ctrl_word[NUM_SRC:1]     = en_q;
    flag_word                = '0;
    flag_word[NUM_SRC-1:0]   = flag_q;
  end

  assign rd_data_o = (rd_sel_i == REG_FLAG) ? flag_word : ctrl_word;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned VEC_W   = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_evt_i,
  input logic               boundary_i,
  input logic               reti_i,
  input logic               irq_o,
  input logic               take_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic               master_i,
  input logic [NUM_SRC-1:0] en_i,
  input logic [NUM_SRC-1:0] flag_i,
  input logic               ctrl_wr_i
);
  logic [NUM_SRC-1:0] below_vec;
  always_comb begin
    below_vec = '0;
    for (int i = 0; i < NUM_SRC; i++) below_vec[i] = (i < int'(vec_o));
  end

  p_take_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (boundary_i && irq_o));

  p_irq_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (master_i && en_i[vec_o] && flag_i[vec_o]));

  p_lowest_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((flag_i & en_i & below_vec) == '0));

  p_master_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !master_i);

  p_flag_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !src_evt_i[vec_o]) |=> !flag_i[$past(vec_o)]);

  p_evt_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_evt_i) |=> (($past(src_evt_i) & ~flag_i) == '0));

  p_reti_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !take_o) |=> master_i);

  p_en_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr_i |=> $stable(en_i));
endmodule

bind irq_ctrl irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_evt_i  (src_evt_i),
  .boundary_i (boundary_i),
  .reti_i     (reti_i),
  .irq_o      (irq_o),
  .take_o     (take_o),
  .vec_o      (vec_o),
  .master_i   (master_q),
  .en_i       (en_q),
  .flag_i     (flag_q),
  .ctrl_wr_i  (ctrl_wr)
);

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] evt = '0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_mask = '0;
  logic [7:0] wr_data = '0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       bnd = 1'b0;
  logic       reti = 1'b0;
  logic       irq;
  logic       take;
  logic [1:0] vec;

  int checks = 0;
  int fails  = 0;

  bit       m_master;
  bit [2:0] m_en;
  bit [2:0] m_flag;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_ctrl dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .src_evt_i  (evt),
    .wr_en_i    (wr_en),
    .wr_sel_i   (wr_sel),
    .wr_mask_i  (wr_mask),
    .wr_data_i  (wr_data),
    .rd_sel_i   (rd_sel),
    .rd_data_o  (rd_data),
    .boundary_i (bnd),
    .reti_i     (reti),
    .irq_o      (irq),
    .take_o     (take),
    .vec_o      (vec)
  );

  task automatic expect_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag, output bit e_take, output int e_vec);
    bit [2:0] pend;
    bit       e_irq;
    pend  = m_flag & m_en & {3{m_master}};
    e_irq = |pend;
    e_vec = 0;
    for (int i = 2; i >= 0; i--) if (pend[i]) e_vec = i;
    e_take = bnd && e_irq;
    expect_eq(tag, "irq", int'(irq), int'(e_irq));
    expect_eq(tag, "take", int'(take), int'(e_take));
    if (e_irq) expect_eq(tag, "vec", int'(vec), e_vec);
    rd_sel = 1'b0;
    #1;
    expect_eq(tag, "ctrl reg", int'(rd_data), int'({4'b0, m_en, m_master}));
    rd_sel = 1'b1;
    #1;
    expect_eq(tag, "flag reg", int'(rd_data), int'({5'b0, m_flag}));
  endtask

  task automatic cyc(string tag, bit [2:0] e, bit we, bit sel, bit [7:0] msk,
                     bit [7:0] dat, bit b, bit r);
    bit e_take;
    int e_vec;
    @(negedge clk);
    evt = e; wr_en = we; wr_sel = sel; wr_mask = msk; wr_data = dat;
    bnd = b; reti = r;
    #1;
    compare(tag, e_take, e_vec);
    if (we && !sel && msk[0]) m_master = dat[0];
    if (r) m_master = 1'b1;
    if (e_take) m_master = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (we && !sel && msk[k+1]) m_en[k] = dat[k+1];
      if (we && sel && msk[k]) m_flag[k] = dat[k];
      if (e_take && e_vec == k) m_flag[k] = 1'b0;
      if (e[k]) m_flag[k] = 1'b1;
    end
  endtask

  task automatic idle(string tag);
    cyc(tag, 3'b000, 0, 0, 8'h00, 8'h00, 0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit dummy_take;
    int dummy_vec;
    m_master = 0; m_en = '0; m_flag = '0;
    repeat (2) @(negedge clk);
    #1;
    compare("R1", dummy_take, dummy_vec);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1");

    // R2: events latch while everything is disabled; R5: boundary alone takes nothing
    cyc("R2", 3'b101, 0, 0, 8'h00, 8'h00, 0, 0);
    cyc("R5", 3'b000, 0, 0, 8'h00, 8'h00, 1, 0);

    // R8: masked writes, upper bits ignored
    cyc("R8", 3'b000, 1, 0, 8'h0E, 8'h0A, 0, 0);
    cyc("R8", 3'b000, 1, 0, 8'h04, 8'hFF, 0, 0);
    cyc("R8", 3'b000, 1, 0, 8'hF0, 8'hF0, 0, 0);
    cyc("R8", 3'b000, 1, 1, 8'hF8, 8'hFF, 0, 0);
    idle("R8");

    // R3: master on
    cyc("R3", 3'b010, 1, 0, 8'h01, 8'h01, 0, 0);
    idle("R4");

    // R5/R6: take external
    cyc("R6", 3'b000, 0, 0, 8'h00, 8'h00, 1, 0);
    idle("R6");
    cyc("R5", 3'b000, 0, 0, 8'h00, 8'h00, 1, 0);

    // R7: return re-arms, timer 0 next
    cyc("R7", 3'b000, 0, 0, 8'h00, 8'h00, 0, 1);
    idle("R4");

    // R9: event on the source being taken
    cyc("R9", 3'b010, 0, 0, 8'h00, 8'h00, 1, 0);
    idle("R9");

    // R11: nesting by software set of master inside handler
    cyc("R11", 3'b000, 1, 0, 8'h01, 8'h01, 0, 0);
    cyc("R11", 3'b000, 0, 0, 8'h00, 8'h00, 1, 0);
    cyc("R11", 3'b000, 1, 0, 8'h01, 8'h01, 0, 0);
    cyc("R11", 3'b000, 0, 0, 8'h00, 8'h00, 1, 0);
    idle("R11");

    // R10: take against software set and against return
    cyc("R10", 3'b011, 0, 0, 8'h00, 8'h00, 0, 1);
    cyc("R10", 3'b000, 1, 0, 8'h01, 8'h01, 1, 0);
    idle("R10");
    cyc("R10", 3'b000, 0, 0, 8'h00, 8'h00, 0, 1);
    cyc("R10", 3'b000, 0, 0, 8'h00, 8'h00, 1, 1);
    idle("R10");

    // R3: flag set but source disabled gives no request
    cyc("R3", 3'b000, 1, 0, 8'h0F, 8'h09, 0, 0);
    cyc("R3", 3'b000, 1, 1, 8'h07, 8'h01, 1, 0);
    cyc("R3", 3'b000, 0, 0, 8'h00, 8'h00, 1, 0);

    // R4: all three pending, order ext > tmr0 > tmr1
    cyc("R4", 3'b111, 1, 0, 8'h0F, 8'h0F, 0, 0);
    cyc("R4", 3'b000, 0, 0, 8'h00, 8'h00, 1, 0);
    cyc("R4", 3'b000, 0, 0, 8'h00, 8'h00, 0, 1);
    cyc("R4", 3'b000, 0, 0, 8'h00, 8'h00, 1, 0);
    cyc("R4", 3'b000, 0, 0, 8'h00, 8'h00, 0, 1);
    cyc("R4", 3'b000, 0, 0, 8'h00, 8'h00, 1, 0);
    cyc("R4", 3'b000, 0, 0, 8'h00, 8'h00, 0, 1);

    // R8: software clears flags
    cyc("R8", 3'b100, 1, 1, 8'h07, 8'h00, 0, 0);
    cyc("R8", 3'b000, 1, 1, 8'h04, 8'h00, 0, 0);
    idle("R8");

    summary();
    $finish;
  end
endmodule